// File: doc/BRIEF.md
# Segment-Offset Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address. It holds four segment registers: code, data, stack and extra. A requester gives the kind of access and an offset. The block picks the segment for that kind, shifts it left by four bits, adds the offset and drops any carry out of the top bit. The result and the segment that was chosen come out one cycle later.

Software loads the data, stack and extra registers through a general load port. The code register ignores that port. It changes only on a separate far-jump load strobe. For data and stack accesses, an override input can pick any of the four segments. Instruction fetches and string-destination accesses always keep their own segment.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset all four segment registers hold 0000h, and addrValid, physAddr and segUsed are all zero.
- R2: One cycle after a request, physAddr equals segment*16 + offset. For example A1F0h:04C0h gives A23C0h, 2000h:3000h gives 23000h, and 28F3h:0000h and 28F2h:0010h both give 28F30h.
- R3: A carry out of bit 19 is dropped, so the address wraps modulo 2^20. FFFFh:0010h gives 00000h.
- R4: A fetch (reqKind 0) uses the code segment (segUsed 0). ovrEn has no effect on it.
- R5: A data access (reqKind 1) with ovrEn low uses the data segment (segUsed 1).
- R6: A stack access (reqKind 2) with ovrEn low uses the stack segment (segUsed 2).
- R7: A string-destination access (reqKind 3) uses the extra segment (segUsed 3). ovrEn has no effect on it.
- R8: For a data or stack access with ovrEn high, the block uses the segment named by ovrSel (0 code, 1 data, 2 stack, 3 extra) and reports it on segUsed.
- R9: A general load with segLoadSel 0 leaves the code register unchanged. segLoadSel 1, 2 and 3 write data, stack and extra.
- R10: farJmpEn writes farJmpVal into the code register.
- R11: A segment load is seen by requests from the next cycle on. A request in the same cycle as the load uses the old value.
- R12: addrValid is reqValid delayed by one cycle. While no request is given, physAddr and segUsed hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segLoadEn | input | 1 | General segment load strobe |
| segLoadSel | input | 2 | Target of the general load (0 is ignored) |
| segLoadVal | input | 16 | Value for the general load |
| farJmpEn | input | 1 | Code segment load strobe |
| farJmpVal | input | 16 | New code segment value |
| reqValid | input | 1 | Address request |
| reqKind | input | 2 | 0 fetch, 1 data, 2 stack, 3 string destination |
| reqOffset | input | 16 | Offset within the segment |
| ovrEn | input | 1 | Segment override enable |
| ovrSel | input | 2 | Override segment |
| addrValid | output | 1 | Result valid |
| physAddr | output | 20 | Physical address |
| segUsed | output | 2 | Segment that formed physAddr |

## Verification
Each result appears exactly one clock edge after its request. The bench drives a request on a falling edge, lets one rising edge pass, and reads addrValid, physAddr and segUsed on the next falling edge. A segment load takes one edge to land. The bench puts a request on the same edge as a load, expects the old value, and expects the new value from the following request.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NSEG = 4;

  typedef enum logic [1:0] {SEG_CODE = 2'd0, SEG_DATA = 2'd1, SEG_STACK = 2'd2, SEG_EXTRA = 2'd3} segId_e;
  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_DATA = 2'd1, ACC_STACK = 2'd2, ACC_STRDST = 2'd3} accKind_e;

  typedef struct packed {
    logic [NSEG-1:0] segWr;
    logic            capture;
    segId_e          rdSel;
  } segCtrl_t;
endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic       segLoadEn,
  input  logic [1:0] segLoadSel,
  input  logic       farJmpEn,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       ovrEn,
  input  logic [1:0] ovrSel,
  output segCtrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (i == int'(SEG_CODE)) ctrl.segWr[i] = farJmpEn;
      else                     ctrl.segWr[i] = segLoadEn && (segLoadSel == 2'(i));
    end
    ctrl.capture = reqValid;
    unique case (accKind_e'(reqKind))
      ACC_FETCH:  ctrl.rdSel = SEG_CODE;
      ACC_DATA:   ctrl.rdSel = ovrEn ? segId_e'(ovrSel) : SEG_DATA;
      ACC_STACK:  ctrl.rdSel = ovrEn ? segId_e'(ovrSel) : SEG_STACK;
      ACC_STRDST: ctrl.rdSel = SEG_EXTRA;
      default:    ctrl.rdSel = SEG_DATA;
    endcase
  end
endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  segCtrl_t          ctrl,
  input  logic [SEG_W-1:0]  segLoadVal,
  input  logic [SEG_W-1:0]  farJmpVal,
  input  logic [OFF_W-1:0]  reqOffset,
  output logic              addrValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic [1:0]        segUsed
);
  logic [SEG_W-1:0]  segFile [NSEG];
  logic [SEG_W-1:0]  segBase;
  logic [ADDR_W-1:0] sumAddr;

  for (genvar g = 0; g < NSEG; g++) begin : gSeg
    logic [SEG_W-1:0] wrVal;
    if (g == int'(SEG_CODE)) begin : gCode
      assign wrVal = farJmpVal;
    end else begin : gGen
      assign wrVal = segLoadVal;
    end
    always_ff @(posedge clk) begin
      if (!rstN)              segFile[g] <= '0;
      else if (ctrl.segWr[g]) segFile[g] <= wrVal;
    end
  end

  assign segBase = segFile[ctrl.rdSel];
  // carry past the top bit is dropped by the width of the sum
  assign sumAddr = {segBase, {SHIFT{1'b0}}} + ADDR_W'(reqOffset);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      physAddr  <= '0;
      segUsed   <= '0;
    end else begin
      addrValid <= ctrl.capture;
      if (ctrl.capture) begin
        physAddr <= sumAddr;
        segUsed  <= ctrl.rdSel;
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  localparam int ADDR_W = SEG_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segLoadEn,
  input  logic [1:0]        segLoadSel,
  input  logic [SEG_W-1:0]  segLoadVal,
  input  logic              farJmpEn,
  input  logic [SEG_W-1:0]  farJmpVal,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic              ovrEn,
  input  logic [1:0]        ovrSel,
  output logic              addrValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic [1:0]        segUsed
);
  segCtrl_t ctrl;

  seg_addr_ctrl uCtrl (
    .segLoadEn(segLoadEn), .segLoadSel(segLoadSel), .farJmpEn(farJmpEn),
    .reqValid(reqValid), .reqKind(reqKind), .ovrEn(ovrEn), .ovrSel(ovrSel),
    .ctrl(ctrl)
  );

  seg_addr_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(4)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .segLoadVal(segLoadVal),
    .farJmpVal(farJmpVal), .reqOffset(reqOffset), .addrValid(addrValid),
    .physAddr(physAddr), .segUsed(segUsed)
  );
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  localparam int ADDR_W = SEG_W + 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              farJmpEn,
  input logic [SEG_W-1:0]  farJmpVal,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [OFF_W-1:0]  reqOffset,
  input logic              ovrEn,
  input logic [1:0]        ovrSel,
  input logic              addrValid,
  input logic [ADDR_W-1:0] physAddr,
  input logic [1:0]        segUsed
);
  logic [SEG_W-1:0] codeShadow;
  always_ff @(posedge clk) begin
    if (!rstN)         codeShadow <= '0;
    else if (farJmpEn) codeShadow <= farJmpVal;
  end

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN) reqValid |=> addrValid);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!addrValid && $stable(physAddr) && $stable(segUsed)));
  // R4
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0) |=> segUsed == 2'd0);
  // R7
  strdst_extra_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd3) |=> segUsed == 2'd3);
  // R5
  data_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd1 && !ovrEn) |=> segUsed == 2'd1);
  // R6
  stack_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd2 && !ovrEn) |=> segUsed == 2'd2);
  // R8
  override_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ovrEn && (reqKind == 2'd1 || reqKind == 2'd2)) |=> segUsed == $past(ovrSel));
  // R10
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd0) |=>
      physAddr == ({$past(codeShadow), 4'b0000} + ADDR_W'($past(reqOffset))));
endmodule

bind seg_addr_gen seg_addr_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W)) uChk (
  .clk(clk), .rstN(rstN), .farJmpEn(farJmpEn), .farJmpVal(farJmpVal),
  .reqValid(reqValid), .reqKind(reqKind), .reqOffset(reqOffset), .ovrEn(ovrEn),
  .ovrSel(ovrSel), .addrValid(addrValid), .physAddr(physAddr), .segUsed(segUsed)
);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic segLoadEn = 0; logic [1:0] segLoadSel = 0; logic [15:0] segLoadVal = 0;
  logic farJmpEn = 0; logic [15:0] farJmpVal = 0;
  logic reqValid = 0; logic [1:0] reqKind = 0; logic [15:0] reqOffset = 0;
  logic ovrEn = 0; logic [1:0] ovrSel = 0;
  logic addrValid; logic [19:0] physAddr; logic [1:0] segUsed;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  seg_addr_gen u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadSeg(logic [1:0] sel, logic [15:0] val);
    @(negedge clk); segLoadEn = 1; segLoadSel = sel; segLoadVal = val;
    @(negedge clk); segLoadEn = 0;
  endtask

  task automatic farJump(logic [15:0] val);
    @(negedge clk); farJmpEn = 1; farJmpVal = val;
    @(negedge clk); farJmpEn = 0;
  endtask

  task automatic doReq(string req, logic [1:0] kind, logic [15:0] off, logic ov, logic [1:0] os,
                       logic [19:0] expAddr, logic [1:0] expSeg);
    @(negedge clk); reqValid = 1; reqKind = kind; reqOffset = off; ovrEn = ov; ovrSel = os;
    @(negedge clk); reqValid = 0; ovrEn = 0;
    check(req, 32'(addrValid), 32'd1);
    check(req, 32'(physAddr), 32'(expAddr));
    check(req, 32'(segUsed), 32'(expSeg));
  endtask

  task automatic testReset();
    check("R1 valid", 32'(addrValid), 0);
    check("R1 addr", 32'(physAddr), 0);
    check("R1 seg", 32'(segUsed), 0);
    doReq("R1 code zero", 2'd0, 16'h0000, 0, 0, 20'h00000, 2'd0);
    doReq("R1 extra zero", 2'd3, 16'h0000, 0, 0, 20'h00000, 2'd3);
  endtask

  task automatic testExamples();
    loadSeg(2'd1, 16'hA1F0);
    doReq("R2 R5 data", 2'd1, 16'h04C0, 0, 0, 20'hA23C0, 2'd1);
    loadSeg(2'd2, 16'h2000);
    doReq("R2 R6 stack", 2'd2, 16'h3000, 0, 0, 20'h23000, 2'd2);
    loadSeg(2'd3, 16'h28F3);
    doReq("R2 R7 alias a", 2'd3, 16'h0000, 0, 0, 20'h28F30, 2'd3);
    loadSeg(2'd3, 16'h28F2);
    doReq("R2 R7 alias b", 2'd3, 16'h0010, 0, 0, 20'h28F30, 2'd3);
  endtask

  task automatic testWrap();
    loadSeg(2'd1, 16'hFFFF);
    doReq("R3 wrap zero", 2'd1, 16'h0010, 0, 0, 20'h00000, 2'd1);
    doReq("R3 wrap high", 2'd1, 16'hFFFF, 0, 0, 20'h0FFEF, 2'd1);
  endtask

  task automatic testOverride();
    doReq("R8 data to extra", 2'd1, 16'h0005, 1, 2'd3, 20'h28F25, 2'd3);
    doReq("R8 stack to code", 2'd2, 16'h0100, 1, 2'd0, 20'h00100, 2'd0);
    doReq("R8 data to stack", 2'd1, 16'h0000, 1, 2'd2, 20'h20000, 2'd2);
    doReq("R4 fetch ignores override", 2'd0, 16'h0040, 1, 2'd1, 20'h00040, 2'd0);
    doReq("R7 strdst ignores override", 2'd3, 16'h0000, 1, 2'd1, 20'h28F20, 2'd3);
  endtask

  task automatic testCodeLoad();
    loadSeg(2'd0, 16'h1234);
    doReq("R9 code not loaded", 2'd0, 16'h0000, 0, 0, 20'h00000, 2'd0);
    farJump(16'h1234);
    doReq("R10 far jump", 2'd0, 16'h0007, 0, 0, 20'h12347, 2'd0);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    segLoadEn = 1; segLoadSel = 2'd1; segLoadVal = 16'h5000;
    reqValid = 1; reqKind = 2'd1; reqOffset = 16'h0000;
    @(negedge clk); segLoadEn = 0; reqValid = 0;
    check("R11 old value", 32'(physAddr), 32'hFFFF0);
    doReq("R11 new value", 2'd1, 16'h0000, 0, 0, 20'h50000, 2'd1);
  endtask

  task automatic testIdle();
    @(negedge clk); @(negedge clk);
    check("R12 idle valid", 32'(addrValid), 0);
    check("R12 idle addr hold", 32'(physAddr), 32'h50000);
    check("R12 idle seg hold", 32'(segUsed), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testExamples();
    testWrap();
    testOverride();
    testCodeLoad();
    testSameCycle();
    testIdle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule